// File: doc/BRIEF.md
# DRAM Strobe-Sequence Cycle Decoder

This block plays the memory side of an asynchronous multiplexed-address DRAM bus inside a synchronous design. The row strobe, the two column strobes (upper and lower byte), the write strobe and the output enable are all sampled on a fast clock. The block works out what kind of access each row cycle is from the order in which those strobes move. It then serves the access from a small on-chip word array, or advances an internal refresh row counter. It is intended as a synthesizable memory stand-in that a DRAM controller can be exercised against.

The strobes pass through two-stage synchronizers, and the block acts on their edges. The row address is captured when the row strobe falls. Each column-strobe fall while the row strobe is low captures a column. Several such falls inside one open row give page-mode accesses. Read data is presented as a data word plus a per-byte drive-enable pair. The enclosing pad logic turns that pair into tri-state control. The refresh counter is exposed so a bench can track refresh coverage. There is no stream traffic, so every pin is a plain level signal and nothing applies back-pressure.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `cycle_kind` is 0 (idle), `dq_oe` is 2'b00 and `refresh_row` is 0.
- R2: A column-strobe fall with the write strobe already low is an early write. `cycle_kind` becomes 2, `dq_in` is stored at the open row and captured column, and `dq_oe` stays 2'b00 for the whole cycle.
- R3: A column-strobe fall with the write strobe high is a read. `cycle_kind` becomes 1 and `dq_out` carries the stored word.
- R4: A byte lane is driven only while its column strobe and the output enable are both low during a read. `dq_oe` returns to 0 for that lane once its column strobe or the output enable goes high.
- R5: A write-strobe fall after a read has put data out is a read-modify-write. `cycle_kind` becomes 3 and `dq_out` keeps the old word. `dq_in` is stored, and a later read returns it.
- R6: A row-strobe fall and rise with both column strobes high is a row-only refresh. `cycle_kind` is 4, `refresh_row` does not change, and stored data is unaffected.
- R7: A row-strobe fall with either column strobe already low, and no column access pending, is a counter refresh. `cycle_kind` becomes 5 and `refresh_row` advances by one.
- R8: A row-strobe fall while the column strobe is still held low from a read in the previous row cycle is a hidden refresh. `cycle_kind` becomes 6, `refresh_row` advances by one, and the read word stays driven on `dq_out`.
- R9: In page mode, each column-strobe fall inside one open row captures a new column in that same row. This holds for both writes and reads.
- R10: `refresh_row` is a 10-bit counter that wraps from 1023 to 0.
- R11: Bit 1 of `dq_oe` and of the write lanes belongs to `dq[15:8]` and the upper strobe. Bit 0 belongs to `dq[7:0]` and the lower strobe. A write with only the lower strobe low leaves bits 15:8 of the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the pads |
| dq_out | output | 16 | Read data toward the pads |
| dq_oe | output | 2 | Per-byte pad drive enable |
| cycle_kind | output | 3 | Current/last cycle: 0 idle, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh |
| refresh_row | output | 10 | Next row of the internal refresh counter |

## Verification
A strobe change goes through two synchronizer flops before its edge is seen, and it takes effect at the third rising clock edge after the pins change. `cycle_kind`, `dq_out` and `refresh_row` are therefore due three edges later. `dq_oe` is due at that same edge, because it combines the registered read-valid flag with the synchronized strobe levels. The bench changes pins on falling edges, waits four full clocks after every change, and samples on a falling edge, so each check lands one cycle after its result is due and well away from any active edge.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [2:0] {
    K_IDLE   = 3'd0,
    K_READ   = 3'd1,
    K_EWRITE = 3'd2,
    K_RMW    = 3'd3,
    K_RONLY  = 3'd4,
    K_CBR    = 3'd5,
    K_HIDDEN = 3'd6
  } cyc_kind_e;
endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcm_refresh_ctr.sv
module dcm_refresh_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  AST_CTR_MOVES_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> $past(inc));  // R7
  AST_CTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc) && $past(cnt) == TOP) |-> (cnt == '0));  // R10
endmodule

// File: rtl/dcm_array.sv
module dcm_array #(
  parameter int DW = 16,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_lane,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << IW;
  localparam int LW    = DW / 2;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_lane[g]) mem[wr_idx][g*LW +: LW] <= wr_data[g*LW +: LW];
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int AW       = 10,
  parameter int DW       = 16,
  parameter int ROW_SEL  = 3,
  parameter int COL_SEL  = 3,
  parameter int REF_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                ucas_n,
  input  logic                lcas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       dq_in,
  output logic [DW-1:0]       dq_out,
  output logic [1:0]          dq_oe,
  output logic [2:0]          cycle_kind,
  output logic [REF_BITS-1:0] refresh_row
);
  import dcm_pkg::*;
  localparam int IW = ROW_SEL + COL_SEL;

  logic [4:0] strobes_s;
  logic ras_s, ucas_s, lcas_s, we_s, oe_s;

  dcm_sync #(.W(5), .RST_VAL(5'b11111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ras_n, ucas_n, lcas_n, we_n, oe_n}),
    .q(strobes_s)
  );
  assign {ras_s, ucas_s, lcas_s, we_s, oe_s} = strobes_s;

  logic ras_lo, cas_lo, ras_lo_q, cas_lo_q, we_q;
  assign ras_lo = !ras_s;
  assign cas_lo = !ucas_s || !lcas_s;

  logic ras_fall, cas_fall_ok, cas_rise, we_fall, rmw_go;
  cyc_kind_e kind_q;
  logic [ROW_SEL-1:0] row_q;
  logic [COL_SEL-1:0] col_q;
  logic out_valid, col_active, cbr_q;
  logic [DW-1:0] out_word, rd_data;

  assign ras_fall    = ras_lo && !ras_lo_q;
  assign cas_fall_ok = cas_lo && !cas_lo_q && ras_lo && ras_lo_q && !cbr_q;
  assign cas_rise    = !cas_lo && cas_lo_q;
  assign we_fall     = !we_s && we_q;
  assign rmw_go      = we_fall && ras_lo && cas_lo && out_valid
                       && (kind_q == K_READ) && !cas_fall_ok;

  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  assign rd_idx = {row_q, addr[COL_SEL-1:0]};
  assign wr_en  = (cas_fall_ok && !we_s) || rmw_go;
  assign wr_idx = rmw_go ? {row_q, col_q} : rd_idx;

  dcm_array #(.DW(DW), .IW(IW)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_lane({!ucas_s, !lcas_s}), .wr_data(dq_in),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  dcm_refresh_ctr #(.CW(REF_BITS)) u_ref (
    .clk(clk), .rst_n(rst_n), .inc(ras_fall && cas_lo), .cnt(refresh_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_q   <= 1'b0;
      cas_lo_q   <= 1'b0;
      we_q       <= 1'b1;
      kind_q     <= K_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      out_valid  <= 1'b0;
      col_active <= 1'b0;
      cbr_q      <= 1'b0;
      out_word   <= '0;
    end else begin
      ras_lo_q <= ras_lo;
      cas_lo_q <= cas_lo;
      we_q     <= we_s;
      if (ras_fall) begin
        if (cas_lo) begin
          kind_q <= col_active ? K_HIDDEN : K_CBR;
          cbr_q  <= 1'b1;
        end else begin
          kind_q <= K_RONLY;
          row_q  <= addr[ROW_SEL-1:0];
          cbr_q  <= 1'b0;
        end
      end
      if (cas_fall_ok) begin
        col_q      <= addr[COL_SEL-1:0];
        col_active <= 1'b1;
        if (!we_s) begin
          kind_q    <= K_EWRITE;
          out_valid <= 1'b0;
        end else begin
          kind_q    <= K_READ;
          out_valid <= 1'b1;
          out_word  <= rd_data;
        end
      end
      if (rmw_go) kind_q <= K_RMW;
      if (cas_rise) begin
        col_active <= 1'b0;
        out_valid  <= 1'b0;
      end
    end
  end

  assign dq_out     = out_word;
  assign dq_oe      = {out_valid && !ucas_s && !oe_s, out_valid && !lcas_s && !oe_s};
  assign cycle_kind = kind_q;

  AST_EARLY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_EWRITE) |-> (dq_oe == 2'b00));  // R2
  AST_RMW_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_RMW && $past(kind_q) != K_RMW) |-> ($past(kind_q) == K_READ));  // R5
  AST_RONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_RONLY) |-> (dq_oe == 2'b00));  // R6
endmodule

// File: tb/test_dram_cycle_decoder.sv
`timescale 1ns/1ps
module test_dram_cycle_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [2:0]  cycle_kind;
  logic [9:0]  refresh_row;

  always #2.5 clk = ~clk;

  dram_cycle_decoder i_dram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cycle_kind(cycle_kind), .refresh_row(refresh_row)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_ref = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic row_open(input logic [9:0] r);
    addr = r; settle(); ras_n = 1'b0; settle();
  endtask
  task automatic col_low(input logic [9:0] c, input logic u, input logic l);
    addr = c; settle(); ucas_n = !u; lcas_n = !l; settle();
  endtask
  task automatic col_high();
    ucas_n = 1'b1; lcas_n = 1'b1; settle();
  endtask
  task automatic row_close();
    ras_n = 1'b1; settle();
  endtask

  task automatic do_write(input logic [9:0] r, input logic [9:0] c, input logic [15:0] d);
    we_n = 1'b0; dq_in = d;
    row_open(r); col_low(c, 1'b1, 1'b1);
    chk("R2 kind", cycle_kind, 3'd2);
    chk("R2 quiet", dq_oe, 2'b00);
    col_high(); row_close(); we_n = 1'b1;
  endtask

  task automatic do_read(input logic [9:0] r, input logic [9:0] c, input logic [15:0] e);
    oe_n = 1'b0;
    row_open(r); col_low(c, 1'b1, 1'b1);
    chk("R3 kind", cycle_kind, 3'd1);
    chk("R3 data", dq_out, e);
    chk("R4 drive", dq_oe, 2'b11);
    col_high();
    chk("R4 release after CAS", dq_oe, 2'b00);
    row_close(); oe_n = 1'b1;
  endtask

  task automatic do_rmw(input logic [9:0] r, input logic [9:0] c, input logic [15:0] d,
                        input logic [15:0] e);
    oe_n = 1'b0;
    row_open(r); col_low(c, 1'b1, 1'b1);
    dq_in = d; we_n = 1'b0; settle();
    chk("R5 kind", cycle_kind, 3'd3);
    chk("R5 old data held", dq_out, e);
    oe_n = 1'b1; col_high(); row_close(); we_n = 1'b1;
  endtask

  task automatic do_cbr();
    ucas_n = 1'b0; lcas_n = 1'b0; settle();
    ras_n = 1'b0; settle();
    exp_ref = (exp_ref + 1) % 1024;
    row_close(); col_high();
  endtask

  // op(2) row(10) col(10) data(16) expected(16); op 0 write, 1 read, 2 rmw
  localparam logic [53:0] VEC [8] = '{
    {2'd0, 10'd1, 10'd2, 16'hA5A5, 16'h0000},
    {2'd0, 10'd1, 10'd3, 16'h1234, 16'h0000},
    {2'd0, 10'd5, 10'd2, 16'hBEEF, 16'h0000},
    {2'd1, 10'd1, 10'd2, 16'h0000, 16'hA5A5},
    {2'd1, 10'd5, 10'd2, 16'h0000, 16'hBEEF},
    {2'd2, 10'd1, 10'd3, 16'h5678, 16'h1234},
    {2'd1, 10'd1, 10'd3, 16'h0000, 16'h5678},
    {2'd1, 10'd1, 10'd2, 16'h0000, 16'hA5A5}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 kind", cycle_kind, 3'd0);
    chk("R1 oe", dq_oe, 2'b00);
    chk("R1 refresh", refresh_row, 10'd0);
    rst_n = 1'b1; settle();

    for (int i = 0; i < 8; i++) begin
      case (VEC[i][53:52])
        2'd0: do_write(VEC[i][51:42], VEC[i][41:32], VEC[i][31:16]);
        2'd1: do_read(VEC[i][51:42], VEC[i][41:32], VEC[i][15:0]);
        default: do_rmw(VEC[i][51:42], VEC[i][41:32], VEC[i][31:16], VEC[i][15:0]);
      endcase
    end

    // R6: row-only refresh
    row_open(10'd1); row_close();
    chk("R6 kind", cycle_kind, 3'd4);
    chk("R6 counter still", refresh_row, 10'(exp_ref));
    do_read(10'd1, 10'd2, 16'hA5A5);

    // R7: counter refresh
    do_cbr();
    chk("R7 kind", cycle_kind, 3'd5);
    chk("R7 counter", refresh_row, 10'(exp_ref));

    // R4: output enable gating
    row_open(10'd5); col_low(10'd2, 1'b1, 1'b1);
    chk("R4 no drive with OE high", dq_oe, 2'b00);
    oe_n = 1'b0; settle();
    chk("R4 drive on OE", dq_oe, 2'b11);
    oe_n = 1'b1; settle();
    chk("R4 release after OE", dq_oe, 2'b00);
    col_high(); row_close();

    // R8: hidden refresh after a read
    oe_n = 1'b0;
    row_open(10'd5); col_low(10'd2, 1'b1, 1'b1);
    row_close(); ras_n = 1'b0; settle();
    exp_ref = (exp_ref + 1) % 1024;
    chk("R8 kind", cycle_kind, 3'd6);
    chk("R8 counter", refresh_row, 10'(exp_ref));
    chk("R8 data kept", dq_out, 16'hBEEF);
    chk("R8 still driven", dq_oe, 2'b11);
    row_close(); col_high(); oe_n = 1'b1;

    // R9: page mode writes and reads in one row
    we_n = 1'b0; row_open(10'd2);
    dq_in = 16'h1111; col_low(10'd4, 1'b1, 1'b1); col_high();
    dq_in = 16'h2222; col_low(10'd6, 1'b1, 1'b1); col_high();
    row_close(); we_n = 1'b1;
    oe_n = 1'b0; row_open(10'd2);
    col_low(10'd4, 1'b1, 1'b1);
    chk("R9 page col a", dq_out, 16'h1111); col_high();
    col_low(10'd6, 1'b1, 1'b1);
    chk("R9 page col b", dq_out, 16'h2222); col_high();
    row_close(); oe_n = 1'b1;

    // R11: lower-lane-only write, then lane drive
    we_n = 1'b0; dq_in = 16'hCDEF;
    row_open(10'd2); col_low(10'd4, 1'b0, 1'b1); col_high(); row_close(); we_n = 1'b1;
    oe_n = 1'b0; row_open(10'd2); col_low(10'd4, 1'b0, 1'b1);
    chk("R11 lane drive", dq_oe, 2'b01);
    chk("R11 merged word", dq_out, 16'h11EF);
    col_high(); row_close(); oe_n = 1'b1;

    // R10: counter wrap
    while (exp_ref != 1023) do_cbr();
    chk("R10 at top", refresh_row, 10'd1023);
    do_cbr();
    chk("R10 wrap", refresh_row, 10'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule